// File: doc/BRIEF.md
# H-Bridge Mode Decoder with Crossover Delay

This block turns the logic-level commands of a brushed DC motor full bridge into four gate enables, one for each switch of the bridge: high and low on leg A, high and low on leg B. Two direction inputs select the bridge mode: forward, reverse, brake, or coast. A chopper input from the current regulator marks the off-time of the current chopper. During that off-time the block turns on the low-side switch of the driven leg. This gives synchronous-rectified slow decay: the load current circulates through both low-side switches instead of through a body diode.

Every switch is turned on only after its leg has been fully off for a programmable dead time, so the high and low switches of one leg never conduct together. An active-low sleep input and an overtemperature input force every switch off. After sleep is released, a wake-up timer ignores commands until the supply circuits have had time to settle, and a ready flag reports when commands are accepted again. All control inputs are plain synchronous levels. The outputs are registered and change one clock after the request, or later when the dead time applies.

Top module: `hbridge_mode_dec`

## Requirements
- R1: With dir_a=1, dir_b=0 and chop_on=1 (forward), the block drives hs_a and ls_b, and holds hs_b and ls_a low.
- R2: With dir_a=0, dir_b=1 and chop_on=1 (reverse), the block drives hs_b and ls_a, and holds hs_a and ls_b low.
- R3: With dir_a=1 and dir_b=1 (brake), the block drives ls_a and ls_b and holds both high sides low, whatever the value of chop_on.
- R4: With dir_a=0 and dir_b=0 (coast), all four gate enables are low, whatever the value of chop_on.
- R5: In forward or reverse with chop_on=0, the high side of the driven leg turns off and both low sides are driven (slow decay with synchronous rectification).
- R6: A request to turn a switch off takes effect at the first clock edge. A switch turns on only after its leg has had both switches off for DEAD_CYC consecutive cycles. After a handover on a leg, the new switch rises exactly DEAD_CYC edges after the old one fell.
- R7: hs_a and ls_a are never high together, and neither are hs_b and ls_b.
- R8: While sleep_n is low, all gate enables and ready are low from the next clock edge on.
- R9: ready rises at the WAKE_CYC-th clock edge after sleep_n rises. Until then, direction commands have no effect and all gate enables stay low.
- R10: While over_temp is high, all gate enables are low from the next clock edge on. After it clears, the commanded mode returns.
- R11: During and right after reset, all gate enables and ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_a | input | 1 | Direction input A |
| dir_b | input | 1 | Direction input B |
| sleep_n | input | 1 | Active-low sleep request |
| chop_on | input | 1 | Chopper source phase (0 = chopper off-time) |
| over_temp | input | 1 | Overtemperature indication, forces outputs off |
| hs_a | output | 1 | High-side gate enable, leg A |
| hs_b | output | 1 | High-side gate enable, leg B |
| ls_a | output | 1 | Low-side gate enable, leg A |
| ls_b | output | 1 | Low-side gate enable, leg B |
| ready | output | 1 | Wake-up delay complete, commands accepted |

## Verification
The chopper off-time and the dead-time rule act in the same cycle when chop_on falls while the bridge drives forward or reverse. The high side must drop at once, but the rectifying low side on that leg has to wait out the dead time. At the same time, the other leg must keep its low side on without a gap. The bench drops chop_on on a driving bridge, samples every cycle of the handover, and checks that the new low side rises exactly DEAD_CYC edges after the high side fell. It also checks that the opposite leg never blinks. A reversal, where both legs hand over together, and the return from off-time are judged the same way.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
  typedef enum logic [1:0] {
    LEG_OFF = 2'b00,
    LEG_HI  = 2'b01,
    LEG_LO  = 2'b10
  } leg_e;
endpackage

// File: rtl/hbd_wake.sv
module hbd_wake #(
  parameter int unsigned WAKE_CYC = 300000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_n,
  output logic ready
);
  localparam int unsigned WW = $clog2(WAKE_CYC + 1);
  localparam logic [WW-1:0] LAST = WW'(WAKE_CYC - 1);
  localparam logic [WW-1:0] SAT  = WW'(WAKE_CYC);

  logic [WW-1:0] wk_cnt;

  // Counts cycles spent awake; sleeping restarts the settling window.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wk_cnt <= '0;
      ready  <= 1'b0;
    end else if (!sleep_n) begin
      wk_cnt <= '0;
      ready  <= 1'b0;
    end else begin
      if (wk_cnt < SAT) wk_cnt <= wk_cnt + 1'b1;
      if (wk_cnt >= LAST) ready <= 1'b1;
    end
  end
endmodule

// File: rtl/hbd_mode_map.sv
module hbd_mode_map
  import hbd_pkg::*;
(
  input  logic enable,
  input  logic dir_a,
  input  logic dir_b,
  input  logic chop_on,
  output leg_e req_a,
  output leg_e req_b
);
  always_comb begin
    req_a = LEG_OFF;
    req_b = LEG_OFF;
    if (enable) begin
      unique case ({dir_a, dir_b})
        2'b10: begin
          // forward; off-time rectifies through leg A low side
          req_a = chop_on ? LEG_HI : LEG_LO;
          req_b = LEG_LO;
        end
        2'b01: begin
          req_a = LEG_LO;
          req_b = chop_on ? LEG_HI : LEG_LO;
        end
        2'b11: begin
          req_a = LEG_LO;
          req_b = LEG_LO;
        end
        default: begin
          req_a = LEG_OFF;
          req_b = LEG_OFF;
        end
      endcase
    end
  end
endmodule

// File: rtl/hbd_leg.sv
module hbd_leg
  import hbd_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  leg_e req,
  output logic hi_en,
  output logic lo_en
);
  localparam int unsigned CW = $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] GO  = CW'(DEAD_CYC - 1);
  localparam logic [CW-1:0] SAT = CW'(DEAD_CYC);

  leg_e          cur, nxt;
  logic [CW-1:0] idle_cnt;

  always_comb begin
    nxt = LEG_OFF;
    if (cur != LEG_OFF) begin
      // any change of request first drops the leg to off
      nxt = (req == cur) ? cur : LEG_OFF;
    end else if (req != LEG_OFF && idle_cnt >= GO) begin
      nxt = req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur      <= LEG_OFF;
      idle_cnt <= SAT;
    end else begin
      cur <= nxt;
      if (cur != LEG_OFF) idle_cnt <= '0;
      else if (idle_cnt < SAT) idle_cnt <= idle_cnt + 1'b1;
    end
  end

  assign hi_en = (cur == LEG_HI);
  assign lo_en = (cur == LEG_LO);
endmodule

// File: rtl/hbridge_mode_dec.sv
module hbridge_mode_dec
  import hbd_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 100,
  parameter int unsigned WAKE_CYC = 300000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dir_a,
  input  logic dir_b,
  input  logic sleep_n,
  input  logic chop_on,
  input  logic over_temp,
  output logic hs_a,
  output logic hs_b,
  output logic ls_a,
  output logic ls_b,
  output logic ready
);
  localparam int unsigned NLEG = 2;

  leg_e       req [NLEG];
  logic [NLEG-1:0] hi_v, lo_v;
  logic       enable;

  hbd_wake #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk     (clk),
    .rst_n   (rst_n),
    .sleep_n (sleep_n),
    .ready   (ready)
  );

  assign enable = ready && sleep_n && !over_temp;

  hbd_mode_map u_map (
    .enable  (enable),
    .dir_a   (dir_a),
    .dir_b   (dir_b),
    .chop_on (chop_on),
    .req_a   (req[0]),
    .req_b   (req[1])
  );

  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    hbd_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req[g]),
      .hi_en (hi_v[g]),
      .lo_en (lo_v[g])
    );
  end

  assign hs_a = hi_v[0];
  assign ls_a = lo_v[0];
  assign hs_b = hi_v[1];
  assign ls_b = lo_v[1];
endmodule

// File: rtl/hbd_checker.sv
module hbd_checker #(
  parameter int unsigned DEAD_CYC = 100
) (
  input logic clk,
  input logic rst_n,
  input logic sleep_n,
  input logic over_temp,
  input logic hs_a,
  input logic hs_b,
  input logic ls_a,
  input logic ls_b,
  input logic ready
);
  localparam int unsigned OW = $clog2(DEAD_CYC + 1) + 1;
  localparam logic [OW-1:0] OSAT = OW'(DEAD_CYC);

  logic [OW-1:0] off_a, off_b;
  logic on_a, on_b;
  assign on_a = hs_a || ls_a;
  assign on_b = hs_b || ls_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_a <= OSAT;
      off_b <= OSAT;
    end else begin
      off_a <= on_a ? '0 : ((off_a < OSAT) ? off_a + 1'b1 : off_a);
      off_b <= on_b ? '0 : ((off_b < OSAT) ? off_b + 1'b1 : off_b);
    end
  end

  AST_LEG_A_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_a && ls_a)); // R7
  AST_LEG_B_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_b && ls_b)); // R7
  AST_DEAD_A: assert property (@(posedge clk) disable iff (!rst_n)
    (on_a && !$past(on_a)) |-> (off_a >= OSAT)); // R6
  AST_DEAD_B: assert property (@(posedge clk) disable iff (!rst_n)
    (on_b && !$past(on_b)) |-> (off_b >= OSAT)); // R6
  AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |=> (!hs_a && !hs_b && !ls_a && !ls_b && !ready)); // R8
  AST_HOT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    over_temp |=> (!hs_a && !hs_b && !ls_a && !ls_b)); // R10
  AST_IDLE_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (!hs_a && !hs_b && !ls_a && !ls_b)); // R9
  AST_READY_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(sleep_n)); // R9
endmodule

bind hbridge_mode_dec hbd_checker #(.DEAD_CYC(DEAD_CYC)) u_hbd_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sleep_n   (sleep_n),
  .over_temp (over_temp),
  .hs_a      (hs_a),
  .hs_b      (hs_b),
  .ls_a      (ls_a),
  .ls_b      (ls_b),
  .ready     (ready)
);

// File: tb/test_hbridge_mode_dec.sv
`timescale 1ns/1ps
module test_hbridge_mode_dec;
  localparam int DEAD = 3;
  localparam int WAKE = 20;
  localparam int NV   = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir_a = 1'b0, dir_b = 1'b0, sleep_n = 1'b1, chop_on = 1'b1, over_temp = 1'b0;
  logic hs_a, hs_b, ls_a, ls_b, ready;

  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hbridge_mode_dec #(.DEAD_CYC(DEAD), .WAKE_CYC(WAKE)) i_hbridge_mode_dec (
    .clk(clk), .rst_n(rst_n), .dir_a(dir_a), .dir_b(dir_b), .sleep_n(sleep_n),
    .chop_on(chop_on), .over_temp(over_temp),
    .hs_a(hs_a), .hs_b(hs_b), .ls_a(ls_a), .ls_b(ls_b), .ready(ready)
  );

  // stimulus {sleep_n, over_temp, dir_a, dir_b, chop_on}
  // expected {ready, hs_a, hs_b, ls_a, ls_b}
  localparam logic [9:0] VEC [NV] = '{
    {5'b10101, 5'b11001},  // R1 forward
    {5'b10100, 5'b10011},  // R5 forward off-time
    {5'b10011, 5'b10110},  // R2 reverse
    {5'b10010, 5'b10011},  // R5 reverse off-time
    {5'b10111, 5'b10011},  // R3 brake, chop on
    {5'b10110, 5'b10011},  // R3 brake, chop off
    {5'b10001, 5'b10000},  // R4 coast, chop on
    {5'b10000, 5'b10000},  // R4 coast, chop off
    {5'b11101, 5'b10000},  // R10 hot in forward
    {5'b11011, 5'b10000},  // R10 hot in reverse
    {5'b10011, 5'b10110},  // R10 cleared, reverse back
    {5'b11111, 5'b10000}   // R10 hot in brake
  };

  function automatic logic [4:0] outs();
    return {ready, hs_a, hs_b, ls_a, ls_b};
  endfunction

  task automatic chk(input string rq, input logic [4:0] got, input logic [4:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: {ready,hs_a,hs_b,ls_a,ls_b} got %b expected %b at %0t", rq, got, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R7 monitor: same-leg switches never on together
  int excl_bad = 0;
  always @(negedge clk) begin
    if (rst_n && ((hs_a && ls_a) || (hs_b && ls_b))) begin
      excl_bad++;
      $display("FAIL R7: leg overlap hs_a=%b ls_a=%b hs_b=%b ls_b=%b expected no overlap", hs_a, ls_a, hs_b, ls_b);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nvec++;
      nbad++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    // R11 reset state
    dir_a = 1'b1; chop_on = 1'b1;
    cyc(3);
    chk("R11", outs(), 5'b00000);
    rst_n = 1'b1;
    cyc(1);
    chk("R11", outs(), 5'b00000);
    // R9 wake-up window: forward command ignored until ready
    cyc(WAKE - 2);
    chk("R9", outs(), 5'b00000);
    cyc(1);
    chk("R9", outs(), 5'b10000);
    cyc(1);
    chk("R1", outs(), 5'b11001);

    for (int i = 0; i < NV; i++) begin
      {sleep_n, over_temp, dir_a, dir_b, chop_on} = VEC[i][9:5];
      cyc(8);
      chk($sformatf("vector %0d (R1-R5,R10 table)", i), outs(), VEC[i][4:0]);
    end

    // R6 / R5 handover into off-time: high side drops at once, low side waits
    {sleep_n, over_temp, dir_a, dir_b, chop_on} = 5'b10101;
    cyc(8);
    chop_on = 1'b0;
    cyc(1);
    chk("R6", outs(), 5'b10001);
    cyc(DEAD - 1);
    chk("R6", outs(), 5'b10001);
    cyc(1);
    chk("R5", outs(), 5'b10011);
    // R6 return from off-time
    chop_on = 1'b1;
    cyc(1);
    chk("R6", outs(), 5'b10001);
    cyc(DEAD - 1);
    chk("R6", outs(), 5'b10001);
    cyc(1);
    chk("R6", outs(), 5'b11001);
    // R6 reversal: both legs hand over together
    dir_a = 1'b0; dir_b = 1'b1;
    cyc(1);
    chk("R6", outs(), 5'b10000);
    cyc(DEAD - 1);
    chk("R6", outs(), 5'b10000);
    cyc(1);
    chk("R2", outs(), 5'b10110);

    // R8 sleep forces all off and drops ready
    sleep_n = 1'b0;
    cyc(1);
    chk("R8", outs(), 5'b00000);
    dir_a = 1'b1; dir_b = 1'b0;
    cyc(4);
    chk("R8", outs(), 5'b00000);
    // R9 wake again with a forward command present
    sleep_n = 1'b1;
    cyc(WAKE - 1);
    chk("R9", outs(), 5'b00000);
    cyc(1);
    chk("R9", outs(), 5'b10000);
    cyc(1);
    chk("R9", outs(), 5'b11001);

    // R10 over_temp: off at next edge, return after clear
    over_temp = 1'b1;
    cyc(1);
    chk("R10", outs(), 5'b10000);
    cyc(5);
    over_temp = 1'b0;
    cyc(2);
    chk("R10", outs(), 5'b11001);

    nvec++;
    if (excl_bad != 0) nbad++;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule